// File: doc/BRIEF.md
# Machine-Cycle Clock Rate Controller

This block turns one oscillator clock into clock-enable strobes: one for the CPU core and one for each of eight peripherals (timer 0, timer 1, timer 2, UART, PCA, watchdog, TWI and SPI). A global double-speed bit picks the CPU rate. In standard mode a machine cycle is 12 oscillator periods and every enable strobes once per `SLOW_DIV` cycles (default 2, which is half the oscillator rate). In double-speed mode a machine cycle is 6 oscillator periods and the CPU enable stays high on every cycle.

Each peripheral has its own rate bit, and that bit only matters while double-speed is on. A clear bit keeps that peripheral at the fast rate. A set bit drops it back to the slow rate. Software writes the bits through a small register port with two 8-bit registers.

Two sleep states gate the strobes. Idle stops the CPU enable and leaves the peripherals running. Power-down stops every enable. A wake input, or reset, leaves both states.

Top module: `cycle_rate_ctrl`

## Requirements
- R1: After reset both registers read 0x00, the block is in neither sleep state, the prescale count is 0, and every enable strobes at the slow rate. The first strobe comes when the count reaches `SLOW_DIV`-1.
- R2: While register 0 bit 0 (double-speed) is 0, the CPU enable and all eight peripheral enables are high only on cycles where the prescale count equals `SLOW_DIV`-1. The peripheral rate bits have no effect.
- R3: While double-speed is 1, the CPU enable is high on every cycle. Each peripheral whose rate bit is 0 also has its enable high on every cycle.
- R4: While double-speed is 1, each peripheral whose rate bit is 1 strobes only on cycles where the count equals `SLOW_DIV`-1.
- R5: Register 0 (reg_sel=0) layout: bit 0 double-speed, bit 1 timer 0, bit 2 timer 1, bit 3 timer 2, bit 4 UART, bit 5 PCA, bit 6 watchdog, bit 7 TWI. Register 1 (reg_sel=1) bit 0 is the SPI rate bit. On per_en, index 0 is timer 0, then 1 timer 1, 2 timer 2, 3 UART, 4 PCA, 5 watchdog, 6 TWI, 7 SPI.
- R6: Bits 7 to 1 of register 1 always read 0, even after a write of 1s to them.
- R7: The prescale count runs freely from 0 to `SLOW_DIV`-1 and then wraps. A rate change written to a register reaches a channel only on the cycle after the count was `SLOW_DIV`-1. This means a slow strobe period is never cut short.
- R8: A cycle with idle_req high (and wake low) enters idle. From the next cycle on, cpu_en is 0 and the peripheral enables keep their pattern.
- R9: A cycle with pd_req high (and wake low) enters power-down. From the next cycle on, cpu_en and all per_en are 0.
- R10: A cycle with wake high clears both idle and power-down, even when a request is high in the same cycle. Reset also clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_sel | input | 1 | Register select: 0 = register 0, 1 = register 1 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| idle_req | input | 1 | Enter idle |
| pd_req | input | 1 | Enter power-down |
| wake | input | 1 | Leave idle and power-down |
| cpu_en | output | 1 | CPU clock enable |
| per_en | output | 8 | Peripheral clock enables, order as in R5 |

## Verification
The bench builds the block with `SLOW_DIV` = 3 instead of the default 2. With a period of 3, the slow strobe no longer lines up with a plain alternating bit. A counter that wraps at the wrong value, or a rate change applied off the boundary, then shows up as a wrong strobe position.

Register writes land at several different prescale phases. This exercises the deferred-switch rule in both directions, from fast to slow and from slow to fast. The sleep sequences also cover a wake that arrives in the same cycle as a request.

// File: rtl/cycle_rate_ctrl.sv
module cycle_rate_ctrl #(
  parameter int SLOW_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       idle_req,
  input  logic       pd_req,
  input  logic       wake,
  output logic       cpu_en,
  output logic [7:0] per_en
);
  localparam int CW  = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam int NCH = 9;
  localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);

  logic [7:0]     ctl0;
  logic           spi_bit;
  logic [CW-1:0]  cnt;
  logic [NCH-1:0] want, slow_q, tick;
  logic           idle_q, pd_q;
  logic           bnd;

  assign bnd = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= bnd ? '0 : cnt + CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl0    <= 8'h00;
      spi_bit <= 1'b0;
    end else if (reg_wr) begin
      if (reg_sel) spi_bit <= reg_wdata[0];
      else         ctl0    <= reg_wdata;
    end

  assign reg_rdata = reg_sel ? {7'b0, spi_bit} : ctl0;

  assign want[8] = ~ctl0[0];
  assign want[7] = ~ctl0[0] | spi_bit;
  for (genvar i = 0; i < 7; i++) begin : g_want
    assign want[i] = ~ctl0[0] | ctl0[i+1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   slow_q <= '1;
    else if (bnd) slow_q <= want;

  assign tick = ~slow_q | {NCH{bnd}};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idle_q <= 1'b0;
      pd_q   <= 1'b0;
    end else if (wake) begin
      idle_q <= 1'b0;
      pd_q   <= 1'b0;
    end else begin
      if (idle_req) idle_q <= 1'b1;
      if (pd_req)   pd_q   <= 1'b1;
    end

  assign cpu_en = tick[8] & ~idle_q & ~pd_q;
  assign per_en = tick[7:0] & {8{~pd_q}};

  p_rate_at_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(slow_q) |-> $past(cnt) == LAST);

  p_idle_stops_cpu_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(idle_req) && !$past(wake)) |-> !cpu_en);

  p_pd_stops_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(pd_req) && !$past(wake)) |-> (!cpu_en && per_en == 8'h00));

  p_wake_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wake)) |-> (!idle_q && !pd_q));
endmodule

// File: tb/sim_cycle_rate_ctrl.sv
module sim_cycle_rate_ctrl;
  localparam int D = 3;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_sel = 0, idle_req = 0, pd_req = 0, wake = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, per_en;
  logic cpu_en;

  int total = 0, bad = 0;
  logic [8:0] expq[$];

  int m_cnt;
  logic [7:0] m_ctl0;
  logic m_spi, m_idle, m_pd;
  logic [8:0] m_slow;

  always #10 clk = ~clk;

  cycle_rate_ctrl #(.SLOW_DIV(D)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .idle_req(idle_req),
    .pd_req(pd_req), .wake(wake), .cpu_en(cpu_en), .per_en(per_en));

  function automatic logic [8:0] want_f(logic [7:0] c0, logic s);
    logic [8:0] w;
    w[8] = ~c0[0];
    w[7] = ~c0[0] | s;
    for (int i = 0; i < 7; i++) w[i] = ~c0[0] | c0[i+1];
    return w;
  endfunction

  task automatic tick();
    logic bnd;
    logic [8:0] t, e;
    @(posedge clk);
    bnd = (m_cnt == D - 1);
    if (bnd) m_slow = want_f(m_ctl0, m_spi);
    m_cnt = bnd ? 0 : m_cnt + 1;
    if (reg_wr) begin
      if (reg_sel) m_spi = reg_wdata[0];
      else         m_ctl0 = reg_wdata;
    end
    if (wake) begin m_idle = 0; m_pd = 0; end
    else begin
      if (idle_req) m_idle = 1;
      if (pd_req)   m_pd = 1;
    end
    t = ~m_slow | {9{m_cnt == D - 1}};
    e[8] = t[8] & ~m_idle & ~m_pd;
    e[7:0] = t[7:0] & {8{~m_pd}};
    expq.push_back(e);
    @(negedge clk);
    #1;
  endtask

  always @(negedge clk) begin
    if (expq.size() > 0) begin
      logic [8:0] e;
      e = expq.pop_front();
      total++;
      if ({cpu_en, per_en} !== e) begin
        bad++;
        $display("FAIL R2 R3 R4 R5 R7 R8 R9 R10 enables got=%h exp=%h", {cpu_en, per_en}, e);
      end
    end
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(logic s, logic [7:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1;
    tick();
    reg_wr = 0;
  endtask

  task automatic chk_rd(logic s, logic [7:0] e, string tag);
    reg_sel = s;
    #1;
    total++;
    if (reg_rdata !== e) begin
      bad++;
      $display("FAIL %s read sel=%0d got=%h exp=%h", tag, s, reg_rdata, e);
    end
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_cnt = 0; m_ctl0 = 0; m_spi = 0; m_idle = 0; m_pd = 0; m_slow = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state
    chk_rd(0, 8'h00, "R1");
    chk_rd(1, 8'h00, "R1");
    total++;
    if ({cpu_en, per_en} !== 9'h000) begin
      bad++; $display("FAIL R1 enables got=%h exp=000", {cpu_en, per_en});
    end
    run(7);
    // R2: peripheral bits ignored while double-speed is 0
    wr(0, 8'hFE);
    chk_rd(0, 8'hFE, "R5");
    run(8);
    // R3: double-speed, all peripherals fast
    wr(0, 8'h01);
    run(8);
    // R4 R5: mixed peripheral bits (timer 1, UART, watchdog slow)
    wr(0, 8'h55);
    run(7);
    // R6: register 1 upper bits read 0; SPI slow
    wr(1, 8'hFF);
    chk_rd(1, 8'h01, "R6");
    run(6);
    // R7: changes written at other phases
    run(1);
    wr(0, 8'hAB);
    run(5);
    wr(1, 8'h00);
    wr(0, 8'h01);
    run(6);
    // R8: idle
    idle_req = 1; tick(); idle_req = 0;
    run(6);
    // R10: wake out of idle
    wake = 1; tick(); wake = 0;
    run(4);
    // R9: power-down from standard mode
    wr(0, 8'h00);
    pd_req = 1; tick(); pd_req = 0;
    run(6);
    // R10: wake together with requests
    wake = 1; idle_req = 1; pd_req = 1; tick();
    wake = 0; idle_req = 0; pd_req = 0;
    run(6);
    // R10: reset clears sleep
    idle_req = 1; tick(); idle_req = 0;
    run(2);
    @(negedge clk);
    rst_n = 0;
    #1;
    expq.delete();
    m_cnt = 0; m_ctl0 = 0; m_spi = 0; m_idle = 0; m_pd = 0; m_slow = '1;
    @(negedge clk);
    rst_n = 1;
    #1;
    chk_rd(0, 8'h00, "R1");
    run(6);
    @(negedge clk);
    #2;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule